// File: doc/BRIEF.md
# Periodic DRAM Row Refresh Scheduler with Bus Arbitration

This block keeps a DRAM array alive by issuing a row refresh at a fixed cadence, and it decides, cycle by cycle, whether the shared memory bus belongs to the CPU or to the refresh logic. A free-running interval timer raises a refresh request once every `INTERVAL` clock cycles. The default of 750 cycles corresponds to roughly 15 µs at a 50 MHz clock. A row counter selects the row to refresh. It walks through `ROWS` rows (64 by default) and then returns to row 0.

Each refresh is a CAS-before-RAS style strobe sequence, timed in whole clock cycles. CAS rises one cycle ahead of RAS. Both strobes are then held for `RAS_CYCLES` cycles with the current row on the row output. A precharge gap of `PRE_CYCLES` cycles follows, with both strobes low. The row counter steps at the moment RAS is released.

The CPU raises a request together with a busy level that it holds until its access is complete. A pending refresh never cuts into a CPU access. However, it wins the bus the moment that access completes, ahead of any new CPU request. A CPU that asks for the bus while a refresh is pending or running sees its wait output asserted until the refresh has finished.

Top module: `refresh_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the row output is 0, RAS, CAS and grant are low, and no refresh is pending. With no CPU traffic, the first refresh starts (CAS high) in the sampling window after clock edge `INTERVAL+1`, counting edges from reset release.
- R2: With no CPU traffic, refresh cycles start every `INTERVAL` cycles from a free-running timer. Refresh k (k ≥ 1) shows CAS high after edge `k*INTERVAL+1`.
- R3: A refresh drives CAS alone for exactly one cycle, then RAS and CAS together for `RAS_CYCLES` cycles, then both low for `PRE_CYCLES` cycles before the bus is released. All strobes are active high.
- R4: The row output increments by one on the edge where RAS falls, and wraps from `ROWS-1` to 0.
- R5: The row output does not change while RAS is held high.
- R6: When the bus is idle and no refresh is pending, a CPU request is granted on the next edge. The grant then stays high for as long as the CPU holds busy, and drops on the first edge that sees busy low.
- R7: A refresh that becomes due during a CPU access produces no strobe while grant is high. That refresh starts (CAS high) one edge after the grant drops, even if a new CPU request is already waiting.
- R8: The wait output is high whenever the CPU requests while a refresh is pending or running. It is low when the CPU requests an idle bus with no refresh pending.
- R9: Grant and either strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU asks for the memory bus |
| cpuBusy | input | 1 | CPU access in progress; held until the access completes |
| refRow | output | $clog2(ROWS) | Row being or next to be refreshed |
| ras | output | 1 | Row strobe, active high |
| cas | output | 1 | Column strobe, active high |
| cpuGrant | output | 1 | Bus currently owned by the CPU |
| cpuWait | output | 1 | CPU request stalled by refresh |

## Verification
The bench sweeps more than 64 refresh periods cycle by cycle and compares the strobe and row values against closed-form expressions in the edge count. A timer that drifts by one cycle, a strobe phase of the wrong length, or a row counter that wraps at the wrong value therefore shows up as a miscompare at a known edge. Directed sequences let a refresh become due in the middle of a CPU access, with a fresh CPU request waiting as that access ends. A design that let the CPU win, or that cut the access short, would raise grant or a strobe at the wrong edge. A request placed in the middle of a refresh checks that the wait level lasts exactly until precharge ends, and that a second reset in mid-run returns the row to 0.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CPU,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rowStep;      // advance row counter this edge
    logic takePending;  // refresh request consumed this edge
  } dpCtrl_t;

endpackage

// File: rtl/refresh_datapath.sv
module refresh_datapath
  import refresh_pkg::*;
#(
  parameter int INTERVAL = 750,
  parameter int ROWS     = 64,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int CNT_W   = $clog2(INTERVAL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  output logic             refPending,
  output logic [ROW_W-1:0] refRow
);

  logic [CNT_W-1:0] timerCnt;
  logic             tickNow;

  assign tickNow = (timerCnt == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (tickNow) begin
      timerCnt <= '0;
    end else begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPending <= 1'b0;
    end else if (tickNow) begin
      refPending <= 1'b1;
    end else if (ctrl.takePending) begin
      refPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refRow <= '0;
    end else if (ctrl.rowStep) begin
      refRow <= (refRow == ROW_W'(ROWS - 1)) ? '0 : refRow + 1'b1;
    end
  end

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int RAS_CYCLES = 3,
  parameter int PRE_CYCLES = 2,
  localparam int PH_MAX    = (RAS_CYCLES > PRE_CYCLES) ? RAS_CYCLES : PRE_CYCLES,
  localparam int PH_W      = $clog2(PH_MAX + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuReq,
  input  logic    cpuBusy,
  input  logic    refPending,
  output dpCtrl_t ctrl,
  output logic    ras,
  output logic    cas,
  output logic    cpuGrant,
  output logic    cpuWait
);

  arbState_t       state, stateNxt;
  logic [PH_W-1:0] phaseCnt, phaseNxt;
  logic            rasLast, preLast;

  assign rasLast = (phaseCnt == PH_W'(RAS_CYCLES - 1));
  assign preLast = (phaseCnt == PH_W'(PRE_CYCLES - 1));

  always_comb begin
    stateNxt         = state;
    phaseNxt         = phaseCnt;
    ctrl.rowStep     = 1'b0;
    ctrl.takePending = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (refPending) begin
          stateNxt         = ST_CAS;
          ctrl.takePending = 1'b1;
        end else if (cpuReq) begin
          stateNxt = ST_CPU;
        end
      end
      ST_CPU: begin
        if (!cpuBusy) stateNxt = ST_IDLE;
      end
      ST_CAS: begin
        stateNxt = ST_RAS;
        phaseNxt = '0;
      end
      ST_RAS: begin
        if (rasLast) begin
          stateNxt     = ST_PRE;
          phaseNxt     = '0;
          ctrl.rowStep = 1'b1;
        end else begin
          phaseNxt = phaseCnt + 1'b1;
        end
      end
      ST_PRE: begin
        if (preLast) begin
          stateNxt = ST_IDLE;
          phaseNxt = '0;
        end else begin
          phaseNxt = phaseCnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= stateNxt;
      phaseCnt <= phaseNxt;
    end
  end

  assign cas      = (state == ST_CAS) || (state == ST_RAS);
  assign ras      = (state == ST_RAS);
  assign cpuGrant = (state == ST_CPU);
  assign cpuWait  = cpuReq && ((state == ST_CAS) || (state == ST_RAS) ||
                               (state == ST_PRE) || ((state == ST_IDLE) && refPending));

endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import refresh_pkg::*;
#(
  parameter int INTERVAL   = 750,
  parameter int ROWS       = 64,
  parameter int RAS_CYCLES = 3,
  parameter int PRE_CYCLES = 2,
  localparam int ROW_W     = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuBusy,
  output logic [ROW_W-1:0] refRow,
  output logic             ras,
  output logic             cas,
  output logic             cpuGrant,
  output logic             cpuWait
);

  dpCtrl_t dpCtrl;
  logic    refPending;

  refresh_datapath #(
    .INTERVAL(INTERVAL),
    .ROWS    (ROWS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .refPending(refPending),
    .refRow    (refRow)
  );

  refresh_ctrl #(
    .RAS_CYCLES(RAS_CYCLES),
    .PRE_CYCLES(PRE_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuBusy   (cpuBusy),
    .refPending(refPending),
    .ctrl      (dpCtrl),
    .ras       (ras),
    .cas       (cas),
    .cpuGrant  (cpuGrant),
    .cpuWait   (cpuWait)
  );

endmodule

// File: rtl/refresh_arbiter_chk.sv
module refresh_arbiter_chk #(
  parameter int ROWS     = 64,
  localparam int ROW_W   = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReq,
  input logic             cpuBusy,
  input logic [ROW_W-1:0] refRow,
  input logic             ras,
  input logic             cas,
  input logic             cpuGrant,
  input logic             cpuWait
);

  // R9
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuGrant |-> !(ras || cas));

  // R3
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ras) |-> $past(cas));

  // R3
  ras_with_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    ras |-> cas);

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ras && $past(ras)) |-> $stable(refRow));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ras) |-> (refRow == (($past(refRow) == ROW_W'(ROWS - 1)) ? '0 : $past(refRow) + 1'b1)));

  // R8
  wait_in_refresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && (ras || cas)) |-> cpuWait);

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuGrant && cpuBusy) |=> cpuGrant);

endmodule

bind refresh_arbiter refresh_arbiter_chk #(.ROWS(ROWS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuBusy (cpuBusy),
  .refRow  (refRow),
  .ras     (ras),
  .cas     (cas),
  .cpuGrant(cpuGrant),
  .cpuWait (cpuWait)
);

// File: tb/refresh_arbiter_tb.sv
module refresh_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int INT_C      = 40;
  localparam int ROWS_C     = 64;
  localparam int RAS_C      = 3;
  localparam int PRE_C      = 2;
  localparam int ROW_W      = $clog2(ROWS_C);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cpuReq = 1'b0;
  logic             cpuBusy = 1'b0;
  logic [ROW_W-1:0] refRow;
  logic             ras, cas, cpuGrant, cpuWait;

  int edgeCnt = 0;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else       edgeCnt <= edgeCnt + 1;
  end

  refresh_arbiter #(
    .INTERVAL  (INT_C),
    .ROWS      (ROWS_C),
    .RAS_CYCLES(RAS_C),
    .PRE_CYCLES(PRE_C)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .cpuReq  (cpuReq),
    .cpuBusy (cpuBusy),
    .refRow  (refRow),
    .ras     (ras),
    .cas     (cas),
    .cpuGrant(cpuGrant),
    .cpuWait (cpuWait)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, edgeCnt, act, exp);
    end
  endtask

  task automatic doReset();
    rstN    = 1'b0;
    cpuReq  = 1'b0;
    cpuBusy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset row", int'(refRow), 0);
    check("R1 reset ras", int'(ras), 0);
    check("R1 reset cas", int'(cas), 0);
    check("R1 reset grant", int'(cpuGrant), 0);
    rstN = 1'b1;
  endtask

  task automatic toEdge(input int e);
    while (edgeCnt < e) @(negedge clk);
  endtask

  initial begin
    // ---------- arbitration scenarios ----------
    doReset();
    toEdge(30);
    cpuReq  = 1'b1;
    cpuBusy = 1'b1;
    toEdge(31);
    check("R6 grant next edge", int'(cpuGrant), 1);
    check("R8 no wait on idle bus", int'(cpuWait), 0);
    cpuReq = 1'b0;
    for (int e = 32; e <= 45; e++) begin
      toEdge(e);
      check("R6 grant held while busy", int'(cpuGrant), 1);
      check("R7 no strobe during cpu", int'(ras | cas), 0);
    end
    cpuBusy = 1'b0;
    cpuReq  = 1'b1;
    toEdge(46);
    check("R6 grant released", int'(cpuGrant), 0);
    check("R8 wait while pending", int'(cpuWait), 1);
    toEdge(47);
    check("R7 refresh before new cpu cas", int'(cas), 1);
    check("R3 cas lead ras low", int'(ras), 0);
    check("R7 no grant", int'(cpuGrant), 0);
    for (int e = 48; e <= 50; e++) begin
      toEdge(e);
      check("R3 ras phase", int'(ras), 1);
      check("R5 row held", int'(refRow), 0);
      check("R8 wait during ras", int'(cpuWait), 1);
    end
    toEdge(51);
    check("R4 row step on ras release", int'(refRow), 1);
    check("R3 precharge strobes", int'(ras | cas), 0);
    toEdge(52);
    check("R8 wait during precharge", int'(cpuWait), 1);
    toEdge(53);
    check("R8 wait cleared", int'(cpuWait), 0);
    check("R3 bus held through precharge", int'(cpuGrant), 0);
    toEdge(54);
    check("R6 grant after refresh", int'(cpuGrant), 1);
    cpuReq = 1'b0;
    toEdge(55);
    check("R6 grant drops without busy", int'(cpuGrant), 0);

    // request arriving mid refresh (tick at 80, cas after 81)
    toEdge(81);
    check("R2 second refresh cas", int'(cas), 1);
    toEdge(82);
    cpuReq  = 1'b1;
    cpuBusy = 1'b1;
    for (int e = 83; e <= 86; e++) begin
      toEdge(e);
      check("R8 wait mid refresh", int'(cpuWait), 1);
      check("R9 no grant mid refresh", int'(cpuGrant), 0);
    end
    toEdge(87);
    check("R8 wait ends after precharge", int'(cpuWait), 0);
    toEdge(88);
    check("R6 grant after stall", int'(cpuGrant), 1);
    check("R4 second row", int'(refRow), 2);
    cpuReq = 1'b0;
    toEdge(89);
    cpuBusy = 1'b0;
    toEdge(92);

    // ---------- mid-run reset, then full sweep ----------
    doReset();
    for (int e = 1; e <= (ROWS_C + 2) * INT_C; e++) begin
      int k, loc, expCas, expRas, expRow;
      toEdge(e);
      k      = e / INT_C;
      loc    = e - k * INT_C;
      expCas = (k >= 1 && loc >= 1 && loc <= 1 + RAS_C) ? 1 : 0;
      expRas = (k >= 1 && loc >= 2 && loc <= 1 + RAS_C) ? 1 : 0;
      expRow = (e >= RAS_C + 2) ? (((e - RAS_C - 2) / INT_C) % ROWS_C) : 0;
      if (k == 0) check("R1 quiet before first interval", int'(cas | ras), 0);
      else begin
        check("R2 cas timing", int'(cas), expCas);
        check("R3 ras timing", int'(ras), expRas);
      end
      check("R4 row sequence and wrap", int'(refRow), expRow);
      check("R9 no grant idle", int'(cpuGrant), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule